// File: doc/BRIEF.md
# Vector Element Extract-Insert Unit

This execution unit takes one element from a source vector and writes it into one chosen element position of a destination vector. Every other destination element keeps its previous value. Elements may be bytes, halfwords, words or doublewords. A narrow form works on 128 bits. A wide form works on 256 bits and repeats the same indexed copy independently in each 128-bit lane.

Each operation arrives as a 32-bit instruction word, together with the 256-bit source value and the old 256-bit destination value. Bits 31:18 of the instruction carry the opcode. The 8-bit immediate in bits 17:10 holds the destination element index in its upper nibble and the source element index in its lower nibble. The register fields in bits 9:0 are not used here. The merged result is registered and appears one cycle after the request. An opcode the unit does not recognise raises a one-cycle illegal flag instead.

Top module: `vxi_unit`

## Requirements
- R1: A request (`in_valid` high) with a recognised opcode gives `out_valid` high exactly one cycle later. A cycle with no request gives `out_valid` and `out_illegal` low in the next cycle, and `out_result` holds its value.
- R2: Opcode 0x1ce3 (narrow) or 0x1de3 (wide) is the byte form. Destination byte imm[7:4] receives source byte imm[3:0].
- R3: Opcode 0x1ce2 or 0x1de2 is the halfword form. Destination halfword imm[6:4] receives source halfword imm[2:0].
- R4: Opcode 0x1ce1 or 0x1de1 is the word form. Destination word imm[5:4] receives source word imm[1:0].
- R5: Opcode 0x1ce0 or 0x1de0 is the doubleword form. Destination doubleword imm[4] receives source doubleword imm[0].
- R6: All destination elements other than the indexed one in each active lane keep their old values.
- R7: The wide forms (0x1dex) do the same indexed copy in bits 255:128, using the upper halves of the source and the old destination.
- R8: The narrow forms (0x1cex) give zero in bits 255:128 of the result.
- R9: Immediate bits that the selected element size does not use have no effect on the result.
- R10: A request with any other opcode gives `out_illegal` high for one cycle and `out_valid` low, and `out_result` keeps its previous value.
- R11: During and right after reset, `out_result` is zero and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_instr | input | 32 | Instruction word: opcode 31:18, immediate 17:10 |
| in_src | input | 256 | Source vector |
| in_dst_old | input | 256 | Previous destination vector |
| out_result | output | 256 | Registered merged result |
| out_valid | output | 1 | Result valid, one cycle after a legal request |
| out_illegal | output | 1 | One-cycle unrecognised-opcode flag |

## Verification
The embedded properties check on every cycle that:
- the latency and exclusivity of the two flags are correct;
- the result is held on an illegal request;
- the upper half is zero after a narrow request;
- exactly one element's worth of bytes in each lane is taken from the source.

Only the bench's scenarios can show that the correct source element lands in the correct destination slot for each size and lane, and that unused immediate bits are ignored. They do this by comparing against an element-level reference model over directed and random instructions.

// File: rtl/vxi_pkg.sv
`timescale 1ns/1ps
package vxi_pkg;
  typedef enum logic [1:0] {ESZ_B = 2'd0, ESZ_H = 2'd1, ESZ_W = 2'd2, ESZ_D = 2'd3} esz_e;

  localparam int OP_W = 14;
  localparam logic [OP_W-3:0] NARROW_BASE = 12'h738;  // 0x1ce0 >> 2
  localparam logic [OP_W-3:0] WIDE_BASE   = 12'h778;  // 0x1de0 >> 2

  typedef struct packed {
    logic       legal;
    logic       wide;
    esz_e       esz;
    logic [3:0] dbyte;  // byte offset of destination element in a lane
    logic [3:0] sbyte;  // byte offset of source element in a lane
  } vxi_dec_t;
endpackage

// File: rtl/vxi_decode.sv
`timescale 1ns/1ps
module vxi_decode
  import vxi_pkg::*;
(
  input  logic [31:0] instr,
  output vxi_dec_t    dec
);
  logic [OP_W-1:0] op;
  logic [7:0]      imm;
  logic [3:0]      idx_mask;
  logic [3:0]      d_idx;
  logic [3:0]      s_idx;
  logic            unused_regs;

  assign op          = instr[31:18];
  assign imm         = instr[17:10];
  assign unused_regs = ^instr[9:0];

  always_comb begin
    dec.legal = (op[OP_W-1:2] == NARROW_BASE) || (op[OP_W-1:2] == WIDE_BASE);
    dec.wide  = (op[OP_W-1:2] == WIDE_BASE);
    dec.esz   = esz_e'(2'd3 - op[1:0]);
    idx_mask  = 4'hF >> dec.esz;
    d_idx     = imm[7:4] & idx_mask;
    s_idx     = imm[3:0] & idx_mask;
    dec.dbyte = d_idx << dec.esz;
    dec.sbyte = s_idx << dec.esz;
  end
endmodule

// File: rtl/vxi_lane_merge.sv
`timescale 1ns/1ps
module vxi_lane_merge
  import vxi_pkg::*;
#(
  parameter int LANE_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  esz_e                    esz,
  input  logic [$clog2(LANE_BYTES)-1:0] dbyte,
  input  logic [$clog2(LANE_BYTES)-1:0] sbyte,
  input  logic [LANE_BYTES*8-1:0] src_lane,
  input  logic [LANE_BYTES*8-1:0] old_lane,
  output logic [LANE_BYTES*8-1:0] out_lane
);
  localparam int IW = $clog2(LANE_BYTES);

  logic [IW-1:0]         emask;
  logic [LANE_BYTES-1:0] hit;

  always_comb emask = IW'((32'd1 << esz) - 32'd1);

  for (genvar k = 0; k < LANE_BYTES; k++) begin : g_byte
    localparam logic [IW-1:0] KI = IW'(k);
    logic [IW-1:0] sidx;
    always_comb begin
      hit[k]  = ((KI & ~emask) == dbyte);
      sidx    = sbyte | (KI & emask);
      out_lane[k*8 +: 8] = hit[k] ? src_lane[sidx*8 +: 8] : old_lane[k*8 +: 8];
    end
  end

  AST_ONE_ELEMENT: assert property (@(posedge clk) disable iff (rst)
    $countones(hit) == (32'd1 << esz)); // R6
endmodule

// File: rtl/vxi_unit.sv
`timescale 1ns/1ps
module vxi_unit
  import vxi_pkg::*;
#(
  parameter int LANE_BYTES = 16,
  parameter int NUM_LANES  = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [31:0]  in_instr,
  input  logic [255:0] in_src,
  input  logic [255:0] in_dst_old,
  output logic [255:0] out_result,
  output logic         out_valid,
  output logic         out_illegal
);
  localparam int LW = LANE_BYTES * 8;
  localparam int VW = LW * NUM_LANES;

  vxi_dec_t        dec;
  logic [VW-1:0]   merged;

  vxi_decode u_dec (.instr(in_instr), .dec(dec));

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LW-1:0] lane_out;
    vxi_lane_merge #(.LANE_BYTES(LANE_BYTES)) u_merge (
      .clk      (clk),
      .rst      (rst),
      .esz      (dec.esz),
      .dbyte    (dec.dbyte[$clog2(LANE_BYTES)-1:0]),
      .sbyte    (dec.sbyte[$clog2(LANE_BYTES)-1:0]),
      .src_lane (in_src[l*LW +: LW]),
      .old_lane (in_dst_old[l*LW +: LW]),
      .out_lane (lane_out)
    );
    if (l == 0) begin : g_base
      assign merged[l*LW +: LW] = lane_out;
    end else begin : g_upper
      assign merged[l*LW +: LW] = dec.wide ? lane_out : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_result  <= '0;
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= in_valid && dec.legal;
      out_illegal <= in_valid && !dec.legal;
      if (in_valid && dec.legal) out_result <= merged;
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_illegal)); // R10
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.legal) |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_illegal && $stable(out_result))); // R1
  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dec.legal) |=> (out_illegal && $stable(out_result))); // R10
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.legal && !dec.wide) |=> (out_result[255:128] == '0)); // R8
endmodule

// File: tb/sim_vxi_unit.sv
`timescale 1ns/1ps
module sim_vxi_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [31:0]  in_instr;
  logic [255:0] in_src, in_dst_old;
  logic [255:0] out_result;
  logic         out_valid, out_illegal;

  int n_chk  = 0;
  int n_fail = 0;
  logic [255:0] exp_res;

  always #5 clk = ~clk;

  vxi_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .in_src(in_src), .in_dst_old(in_dst_old),
    .out_result(out_result), .out_valid(out_valid), .out_illegal(out_illegal)
  );

  function automatic logic [255:0] ref_model(input logic [31:0] ins,
      input logic [255:0] s, input logic [255:0] o, output logic ok);
    logic [13:0] op = ins[31:18];
    logic [7:0]  imm = ins[17:10];
    int nb = 1, di = 0, si = 0, lanes = 1;
    logic [255:0] r;
    ok = 1'b1;
    case (op[1:0])
      2'd3: begin nb = 1; di = int'(imm[7:4]); si = int'(imm[3:0]); end
      2'd2: begin nb = 2; di = int'(imm[6:4]); si = int'(imm[2:0]); end
      2'd1: begin nb = 4; di = int'(imm[5:4]); si = int'(imm[1:0]); end
      default: begin nb = 8; di = int'(imm[4]); si = int'(imm[0]); end
    endcase
    if (op[13:2] == 12'h738) lanes = 1;
    else if (op[13:2] == 12'h778) lanes = 2;
    else ok = 1'b0;
    r = o;
    if (lanes == 1) r[255:128] = '0;
    for (int ln = 0; ln < lanes; ln++)
      for (int b = 0; b < nb; b++)
        r[(ln*16 + di*nb + b)*8 +: 8] = s[(ln*16 + si*nb + b)*8 +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input logic cond, input logic [255:0] act,
                     input logic [255:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic run_op(input string req, input logic [31:0] ins,
                        input logic [255:0] s, input logic [255:0] o);
    logic ok;
    logic [255:0] m;
    @(negedge clk);
    in_valid = 1'b1; in_instr = ins; in_src = s; in_dst_old = o;
    m = ref_model(ins, s, o, ok);
    @(negedge clk);
    in_valid = 1'b0;
    if (ok) begin
      exp_res = m;
      chk(req, out_valid && !out_illegal && out_result == exp_res, out_result, exp_res);
    end else begin
      chk(req, !out_valid && out_illegal && out_result == exp_res, out_result, exp_res);
    end
  endtask

  function automatic logic [31:0] mk(input logic [13:0] op, input logic [7:0] imm);
    return {op, imm, 5'd1, 5'd2};
  endfunction

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [255:0] a, b, r1, r2;
    logic ok;
    void'($urandom(32'd7713));
    rst = 1'b1; in_valid = 1'b0; in_instr = '0; in_src = '0; in_dst_old = '0;
    exp_res = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset", out_result == '0 && !out_valid && !out_illegal, out_result, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 after reset", out_result == '0 && !out_valid && !out_illegal, out_result, '0);

    a = rnd256(); b = rnd256();
    run_op("R2 byte narrow example", 32'h738c6022, a, b);
    run_op("R2 byte wide", mk(14'h1de3, 8'hF0), a, b);
    run_op("R3 half narrow", mk(14'h1ce2, 8'h57), a, b);
    run_op("R3 half wide", mk(14'h1de2, 8'h72), a, b);
    run_op("R4 word narrow", mk(14'h1ce1, 8'h30), a, b);
    run_op("R4 word wide", mk(14'h1de1, 8'h13), a, b);
    run_op("R5 dword narrow", mk(14'h1ce0, 8'h10), a, b);
    run_op("R5 dword wide", mk(14'h1de0, 8'h01), a, b);
    run_op("R8 narrow upper zero", mk(14'h1ce3, 8'h00), a, b);
    run_op("R7 wide upper lane", mk(14'h1de3, 8'h8F), a, b);

    // R9: unused immediate bits must not change the word-form result
    r1 = ref_model(mk(14'h1de1, 8'h21), a, b, ok);
    run_op("R9 word clean imm", mk(14'h1de1, 8'h21), a, b);
    run_op("R9 word noisy imm", mk(14'h1de1, 8'hED), a, b);
    chk("R9 noisy equals clean", out_result == r1, out_result, r1);
    r2 = ref_model(mk(14'h1ce0, 8'h10), a, b, ok);
    run_op("R9 dword noisy imm", mk(14'h1ce0, 8'hFE), a, b);
    chk("R9 dword noisy equals clean", out_result == r2, out_result, r2);

    run_op("R10 illegal opcode", mk(14'h1ce4, 8'h11), rnd256(), rnd256());
    run_op("R10 illegal near wide", mk(14'h1df0, 8'h11), rnd256(), rnd256());
    @(negedge clk);
    chk("R10 illegal one cycle", !out_illegal && !out_valid, out_result, exp_res);
    chk("R1 idle holds result", out_result == exp_res, out_result, exp_res);

    for (int i = 0; i < 400; i++) begin
      logic [13:0] op;
      int pick = $urandom_range(0, 9);
      if (pick < 9) op = {($urandom_range(0, 1) != 0) ? 12'h778 : 12'h738, 2'($urandom_range(0, 3))};
      else op = 14'($urandom);
      run_op("R6 random merge", mk(op, 8'($urandom)), rnd256(), rnd256());
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        chk("R1 random idle", !out_valid && !out_illegal && out_result == exp_res,
            out_result, exp_res);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule